// File: doc/BRIEF.md
# Packed Half-Precision Class Tester

This block classifies every lane of a packed vector of IEEE 754 half-precision values. A category-select byte picks which tests apply: quiet NaN, signaling NaN, positive or negative zero, positive or negative infinity, denormal, and negative finite. For each lane the block ORs the enabled test results into one bit. The bits of all lanes form a 32-bit result mask.

The caller sets how many lanes are active (8, 16 or 32). It can give a per-lane write-enable mask, which applies only while a mask-present flag is high. It can also ask for broadcast, so that every lane classifies element 0. Lanes that are disabled, and all bit positions at or above the active count, read 0.

A request enters on a valid/ready input handshake. The result is registered and leaves on a valid/ready output handshake. The block holds one result. While that result waits on a stalled consumer, the input is back-pressured. When the consumer takes the result in a cycle, the block can accept a new request in that same cycle. Classification never raises a floating-point exception, and the block has no exception outputs.

Top module: `fp16_class_mask`

## Requirements
- R1: Each lane reads its 16-bit value as sign = bit 15, exponent = bits 14:10, mantissa = bits 9:0. An all-ones exponent with a nonzero mantissa is a NaN. The NaN is quiet when mantissa bit 9 is 1 and signaling when that bit is 0.
- R2: Select bit 0 enables quiet NaN, bit 1 positive zero, bit 2 negative zero, bit 3 positive infinity, bit 4 negative infinity, bit 5 denormal, bit 6 negative finite and bit 7 signaling NaN. A lane's bit is the OR of its enabled matches, so a select byte of 0 gives a mask of all zeros.
- R3: Zero is an all-zero exponent with a zero mantissa. Infinity is an all-ones exponent with a zero mantissa. For both, the sign bit chooses between the positive and the negative category.
- R4: Denormal means a zero exponent with a nonzero mantissa, for either sign. Negative finite means the sign is set, the exponent is not all ones and the value is not zero. It therefore includes negative denormals and excludes -0, NaN and infinity.
- R5: When `mask_en` is 1, a lane whose `wen_mask` bit is 0 gives 0. When `mask_en` is 0, `wen_mask` has no effect and every active lane is enabled.
- R6: `len_sel` sets the active lane count: 0 gives 8 lanes, 1 gives 16, and 2 or 3 give 32. Every result bit at or above the active count is 0.
- R7: When `bcast` is 1, every active lane classifies element 0 (bits 15:0 of `src_data`) instead of its own element.
- R8: The result of a request accepted at a clock edge appears on `res_mask` with `out_valid` high right after that edge. If no new request is accepted, `out_valid` falls after the edge where `out_ready` is high.
- R9: Back-pressure works as follows:
  - `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
  - While `out_valid` is high and `out_ready` is low, `res_mask` and `out_valid` hold their values.
- R10: After reset, `out_valid` is 0, `res_mask` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| src_data | input | 512 | Packed half-precision source, lane i at bits 16i+15:16i |
| len_sel | input | 2 | Active lane count select |
| cat_sel | input | 8 | Category-select byte |
| wen_mask | input | 32 | Per-lane write enable |
| mask_en | input | 1 | Write-enable mask present |
| bcast | input | 1 | Classify element 0 in every lane |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_mask | output | 32 | Per-lane class result |

## Verification
The assertions check the handshake on every cycle. They cover the ready rule, one-cycle latency, holding the result under a stall, and draining. They also check that disabled and out-of-range lanes read 0 and that an empty select byte yields an all-zero result. Whether each lane picks the right category for a given encoding can only be shown by the bench, which compares every lane against its own reference model. The same holds for broadcast of element 0 and for the fact that `wen_mask` has no effect when no mask is present. The bench covers ±0, ±infinity, NaN payloads of both kinds and the denormal extremes, plus random vectors.

// File: rtl/fp16cls_pkg.sv
package fp16cls_pkg;
  localparam int HALF_W  = 16;
  localparam int EXP_W   = 5;
  localparam int MANT_W  = 10;
  localparam int NUM_CAT = 8;

  // Category positions within the select byte; software depends on this order.
  localparam int CAT_QNAN    = 0;
  localparam int CAT_PZERO   = 1;
  localparam int CAT_NZERO   = 2;
  localparam int CAT_PINF    = 3;
  localparam int CAT_NINF    = 4;
  localparam int CAT_DENORM  = 5;
  localparam int CAT_NEGFIN  = 6;
  localparam int CAT_SNAN    = 7;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } half_t;
endpackage

// File: rtl/fp16_lane_class.sv
module fp16_lane_class
  import fp16cls_pkg::*;
(
  input  logic [HALF_W-1:0]  value_i,
  input  logic [NUM_CAT-1:0] sel_i,
  output logic               hit_o
);
  half_t              f;
  logic               exp_max;
  logic               exp_min;
  logic               man_zero;
  logic               is_nan;
  logic               is_zero;
  logic [NUM_CAT-1:0] match;

  assign f        = half_t'(value_i);
  assign exp_max  = &f.expo;
  assign exp_min  = ~|f.expo;
  assign man_zero = ~|f.mant;
  assign is_nan   = exp_max & ~man_zero;
  assign is_zero  = exp_min & man_zero;

  always_comb begin
    match              = '0;
    match[CAT_QNAN]    = is_nan &  f.mant[MANT_W-1];
    match[CAT_SNAN]    = is_nan & ~f.mant[MANT_W-1];
    match[CAT_PZERO]   = is_zero & ~f.sign;
    match[CAT_NZERO]   = is_zero &  f.sign;
    match[CAT_PINF]    = exp_max & man_zero & ~f.sign;
    match[CAT_NINF]    = exp_max & man_zero &  f.sign;
    match[CAT_DENORM]  = exp_min & ~man_zero;
    match[CAT_NEGFIN]  = f.sign & ~exp_max & ~is_zero;
  end

  assign hit_o = |(match & sel_i);
endmodule

// File: rtl/fp16_lane_route.sv
module fp16_lane_route
  import fp16cls_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int MIN_LANES = 8
) (
  input  logic [LANES*HALF_W-1:0] src_i,
  input  logic                    bcast_i,
  input  logic [1:0]              len_sel_i,
  input  logic [LANES-1:0]        wen_i,
  input  logic                    mask_en_i,
  output logic [LANES*HALF_W-1:0] lane_val_o,
  output logic [LANES-1:0]        lane_on_o
);
  localparam int CNT_W = $clog2(MIN_LANES * 8 + 1);

  logic [CNT_W-1:0] active_cnt;

  always_comb begin
    int want;
    want = MIN_LANES << ((len_sel_i > 2'd2) ? 2'd2 : len_sel_i);
    if (want > LANES) want = LANES;
    active_cnt = CNT_W'(want);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_range;
    assign in_range   = (CNT_W'(i) < active_cnt);
    assign lane_on_o[i] = in_range & (~mask_en_i | wen_i[i]);
    assign lane_val_o[i*HALF_W +: HALF_W] =
      bcast_i ? src_i[HALF_W-1:0] : src_i[i*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/fp16_result_reg.sv
module fp16_result_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp16_class_mask.sv
module fp16_class_mask
  import fp16cls_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int MIN_LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*HALF_W-1:0] src_data,
  input  logic [1:0]              len_sel,
  input  logic [NUM_CAT-1:0]      cat_sel,
  input  logic [LANES-1:0]        wen_mask,
  input  logic                    mask_en,
  input  logic                    bcast,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES-1:0]        res_mask
);
  logic [LANES*HALF_W-1:0] lane_val;
  logic [LANES-1:0]        lane_on;
  logic [LANES-1:0]        lane_hit;
  logic [LANES-1:0]        next_mask;

  fp16_lane_route #(.LANES(LANES), .MIN_LANES(MIN_LANES)) u_route (
    .src_i     (src_data),
    .bcast_i   (bcast),
    .len_sel_i (len_sel),
    .wen_i     (wen_mask),
    .mask_en_i (mask_en),
    .lane_val_o(lane_val),
    .lane_on_o (lane_on)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_cls
    fp16_lane_class u_cls (
      .value_i(lane_val[i*HALF_W +: HALF_W]),
      .sel_i  (cat_sel),
      .hit_o  (lane_hit[i])
    );
  end

  assign next_mask = lane_hit & lane_on;

  fp16_result_reg #(.W(LANES)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (next_mask),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (res_mask)
  );
endmodule

// File: rtl/fp16_class_mask_chk.sv
module fp16_class_mask_chk
  import fp16cls_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int MIN_LANES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [1:0]              len_sel,
  input logic [NUM_CAT-1:0]      cat_sel,
  input logic [LANES-1:0]        wen_mask,
  input logic                    mask_en,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES-1:0]        res_mask
);
  logic             hs;
  logic [LANES-1:0] keep_q;
  logic             nosel_q;
  logic [LANES-1:0] keep_now;

  assign hs = in_valid & in_ready;

  always_comb begin
    int cnt;
    cnt = MIN_LANES << ((len_sel > 2'd2) ? 2'd2 : len_sel);
    if (cnt > LANES) cnt = LANES;
    for (int i = 0; i < LANES; i++)
      keep_now[i] = (i < cnt) && (!mask_en || wen_mask[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q  <= '0;
      nosel_q <= 1'b0;
    end else if (hs) begin
      keep_q  <= keep_now;
      nosel_q <= (cat_sel == '0);
    end
  end

  assert_reset_idle_R10: assert property (@(posedge clk) !rst_n |=> !out_valid);
  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_mask)));
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> out_valid);
  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !hs) |=> !out_valid);
  assert_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((res_mask & ~keep_q) == '0));
  assert_empty_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nosel_q) |-> (res_mask == '0));
endmodule

bind fp16_class_mask fp16_class_mask_chk #(.LANES(LANES), .MIN_LANES(MIN_LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .len_sel  (len_sel),
  .cat_sel  (cat_sel),
  .wen_mask (wen_mask),
  .mask_en  (mask_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .res_mask (res_mask)
);

// File: tb/fp16_class_mask_tb.sv
module fp16_class_mask_tb;
  localparam int LANES = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [LANES*16-1:0] src_data = '0;
  logic [1:0]       len_sel = 2'd0;
  logic [7:0]       cat_sel = 8'd0;
  logic [LANES-1:0] wen_mask = '0;
  logic             mask_en = 1'b0;
  logic             bcast = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [LANES-1:0] res_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp16_class_mask u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_data(src_data), .len_sel(len_sel), .cat_sel(cat_sel),
    .wen_mask(wen_mask), .mask_en(mask_en), .bcast(bcast),
    .out_valid(out_valid), .out_ready(out_ready), .res_mask(res_mask)
  );

  function automatic bit ref_class(logic [15:0] h, logic [7:0] sel);
    bit s, emax, emin, mz;
    bit [7:0] m;
    s = h[15]; emax = (h[14:10] == 5'h1F); emin = (h[14:10] == 5'h00);
    mz = (h[9:0] == 10'd0);
    m[0] = emax && !mz && h[9];
    m[7] = emax && !mz && !h[9];
    m[1] = emin && mz && !s;
    m[2] = emin && mz && s;
    m[3] = emax && mz && !s;
    m[4] = emax && mz && s;
    m[5] = emin && !mz;
    m[6] = s && !emax && !(emin && mz);
    return |(m & sel);
  endfunction

  function automatic logic [LANES-1:0] ref_mask(logic [LANES*16-1:0] src, logic [1:0] ls,
      logic [7:0] sel, logic [LANES-1:0] wen, bit men, bit bc);
    logic [LANES-1:0] r;
    int cnt;
    cnt = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < cnt && (!men || wen[i]))
        r[i] = ref_class(bc ? src[15:0] : src[i*16 +: 16], sel);
    end
    return r;
  endfunction

  function automatic logic [15:0] corner(int k);
    case (k % 20)
      0: return 16'h0000;  1: return 16'h8000;  2: return 16'h7C00;
      3: return 16'hFC00;  4: return 16'h7E00;  5: return 16'h7C01;
      6: return 16'h7DFF;  7: return 16'h7FFF;  8: return 16'hFFFF;
      9: return 16'hFE00;  10: return 16'h0001; 11: return 16'h03FF;
      12: return 16'h8001; 13: return 16'h83FF; 14: return 16'h3C00;
      15: return 16'hBC00; 16: return 16'h7BFF; 17: return 16'hFBFF;
      18: return 16'hFC01; default: return 16'h0400;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Drive one request with out_ready high, then check the registered result.
  task automatic xact(string req, logic [LANES*16-1:0] s, logic [1:0] ls, logic [7:0] sel,
      logic [LANES-1:0] w, bit men, bit bc);
    logic [LANES-1:0] exp_v;
    @(negedge clk);
    src_data = s; len_sel = ls; cat_sel = sel; wen_mask = w; mask_en = men; bcast = bc;
    in_valid = 1'b1; out_ready = 1'b1;
    exp_v = ref_mask(s, ls, sel, w, men, bc);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    check(req, res_mask, exp_v);
  endtask

  function automatic logic [LANES*16-1:0] corner_vec(int base);
    logic [LANES*16-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*16 +: 16] = corner(base + i);
    return v;
  endfunction

  initial begin
    int seed;
    logic [LANES*16-1:0] v;
    logic [LANES-1:0] expa, expb;
    seed = 32'h5EED;
    void'($urandom(seed));
    #1;
    // R10: reset state
    check("R10 out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 res_mask", res_mask, 32'd0);
    check("R10 in_ready", {31'd0, in_ready}, 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R4: each category alone over all corner encodings
    for (int b = 0; b < 8; b++) begin
      xact("R1 R3 R4 single-cat", corner_vec(0), 2'd2, 8'(1 << b), '0, 1'b0, 1'b0);
      xact("R1 R3 R4 single-cat shifted", corner_vec(12), 2'd2, 8'(1 << b), '0, 1'b0, 1'b0);
    end
    // R2: OR of all categories, and empty select
    xact("R2 all-cat", corner_vec(0), 2'd2, 8'hFF, '0, 1'b0, 1'b0);
    xact("R2 empty-sel", corner_vec(0), 2'd2, 8'h00, '0, 1'b0, 1'b0);
    xact("R2 nan-pair", corner_vec(3), 2'd2, 8'h81, '0, 1'b0, 1'b0);
    // R8: output valid drops after being taken with no new request
    @(negedge clk);
    check("R8 drain", {31'd0, out_valid}, 32'd0);
    // R6: lane-count select
    for (int l = 0; l < 4; l++)
      xact("R6 length", corner_vec(5), 2'(l), 8'hFF, '0, 1'b0, 1'b0);
    // R5: mask present vs ignored
    xact("R5 mask on", corner_vec(0), 2'd2, 8'hFF, 32'hA5C3_0FF0, 1'b1, 1'b0);
    xact("R5 mask ignored", corner_vec(0), 2'd2, 8'hFF, 32'h0000_0000, 1'b0, 1'b0);
    // R7: broadcast of element 0
    v = corner_vec(0); v[15:0] = 16'h83FF;
    xact("R7 bcast", v, 2'd1, 8'h40, '0, 1'b0, 1'b1);
    v[15:0] = 16'h0000;
    xact("R7 bcast zero", v, 2'd2, 8'h02, 32'h0F0F_F0F0, 1'b1, 1'b1);

    // R9: back-pressure
    @(negedge clk);
    v = corner_vec(2);
    expa = ref_mask(v, 2'd2, 8'hFF, '0, 1'b0, 1'b0);
    src_data = v; len_sel = 2'd2; cat_sel = 8'hFF; mask_en = 1'b0; bcast = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
    src_data = corner_vec(7); cat_sel = 8'h21;
    expb = ref_mask(corner_vec(7), 2'd2, 8'h21, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 hold valid", {31'd0, out_valid}, 32'd1);
    check("R9 hold data", res_mask, expa);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 pass-through", res_mask, expb);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [LANES*16-1:0] rv;
      for (int i = 0; i < LANES; i++)
        rv[i*16 +: 16] = ($urandom % 3 == 0) ? 16'($urandom) : corner($urandom % 20);
      xact("R1 R2 R3 R4 R5 R6 R7 random", rv, 2'($urandom % 4), 8'($urandom),
           32'($urandom), 1'($urandom % 2), ($urandom % 5 == 0));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule